// File: doc/BRIEF.md
# Pulse-Shaped 4-QAM Modulator

This block is a digital transmitter. It takes a stream of two-bit symbols and turns it into a passband waveform of unsigned DAC codes, one code per sample strobe. Each symbol has one bit for the in-phase rail and one bit for the quadrature rail. Each bit becomes an amplitude of +1 or −1.

Each rail is shaped with a truncated sinc pulse. The pulse spans 16 symbol periods, so the tails of up to sixteen neighbouring symbols overlap at any sample, and all of them are summed. The carrier runs at one quarter of the sample rate, so each carrier cycle is four samples long. With that choice the mixer only has to pick one rail, negate it or pass it, and needs no multiplier. The mixed value is scaled and saturated, then offset to mid-scale.

A symbol is taken through a valid/ready handshake. The block raises ready only on the strobe that closes a symbol period. If nothing is offered at that point, silence (zero amplitude) is inserted, so earlier pulses die away cleanly.

Top module: `qam4_pulse_mod`

## Requirements
- R1: A synchronous active-high `rst` clears the phase counter and the symbol history, and forces `dac_code` to 128. The next symbol period then starts at phase 0.
- R2: `sym_ready` is high exactly when `sample_en` is high and the phase counter is 15. The phase counter is the number of strobes since reset, modulo 16. A symbol transfers when `sym_valid` and `sym_ready` are both high.
- R3: Every symbol period lasts exactly 16 strobes. The cycle after a transfer opportunity, `sym_ready` is low and the phase is back at 0.
- R4: At phase p, each shaped rail equals the sum over m = 0..15 of a[m]·h[p+16m]. Here a[0] is the newest symbol and h[n] = round(256·sin(πt)/(πt)) with t = (n−128)/16. The value h[128] is 256, and h[n] is 0 wherever t is any other integer.
- R5: `sym_bits[1]` drives the in-phase rail and `sym_bits[0]` drives the quadrature rail. A bit of 1 maps to +1 and a bit of 0 maps to −1.
- R6: The mixed value depends on p mod 4, with I the in-phase sum and Q the quadrature sum:
  - 0 gives +Q
  - 1 gives +I
  - 2 gives −Q
  - 3 gives −I
- R7: If no valid symbol is present at the end of a period, a zero-amplitude symbol enters the history. Sixteen periods of silence return the output to 128.
- R8: `dac_code` equals clamp(floor(mix/4), −128, 127) + 128 for the sample just strobed.
- R9: While `sample_en` is low, `dac_code`, the phase and the history do not change.
- R10: A symbol offered while `sym_ready` is low is not consumed. The symbol still valid at the next transfer opportunity is the one taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Output sample strobe |
| sym_valid | input | 1 | A symbol is offered |
| sym_bits | input | 2 | Symbol: bit 1 in-phase, bit 0 quadrature |
| sym_ready | output | 1 | Symbol accepted on this strobe when valid |
| dac_code | output | 8 | Unsigned output sample, 128 is zero |

## Verification
Six symbol streams are used, and each targets a different fault:
- **Constant all-ones and all-zeros streams:** these show a steady tone, so a sign swap or a wrong rail mapping is visible.
- **Alternating 01/10 stream:** this stacks the pulse tails at their worst case and drives the saturation path.
- **Pseudo-random stream with idle cycles between strobes:** this exposes hold faults and a wrong tap order.
- **Stream with periodic missing symbols:** this exercises zero insertion.
- **Single pulse followed by silence:** this traces the whole pulse and confirms the decay back to mid-scale.

// File: rtl/qam4_pkg.sv
package qam4_pkg;
  // Rounded fixed-point sinc tap; center is the peak index, one is the value of 1.0
  function automatic int sinc_tap(input int n, input int center, input int sps, input int one);
    real t;
    real x;
    if ((n - center) % sps == 0) return (n == center) ? one : 0;
    t = real'(n - center) / real'(sps);
    x = 3.14159265358979 * t;
    return $rtoi($floor(real'(one) * $sin(x) / x + 0.5));
  endfunction
endpackage

// File: rtl/qam4_shaper.sv
module qam4_shaper #(
  parameter int SPS    = 16,
  parameter int TAPS   = 16,
  parameter int COEF_W = 10,
  parameter int SUM_W  = 15,
  localparam int PH_W  = $clog2(SPS)
) (
  input  logic [PH_W-1:0]  phase,
  input  logic [TAPS-1:0]  live,   // slot holds a non-zero symbol
  input  logic [TAPS-1:0]  pos,    // slot amplitude +1 when set, -1 otherwise
  output logic signed [SUM_W-1:0] sum
);
  localparam int ONE    = 2 ** (COEF_W - 2);
  localparam int CENTER = SPS * TAPS / 2;

  logic signed [SUM_W-1:0] term [TAPS];

  for (genvar m = 0; m < TAPS; m++) begin : g_bank
    logic signed [COEF_W-1:0] bank [SPS];
    for (genvar p = 0; p < SPS; p++) begin : g_tap
      assign bank[p] = COEF_W'(qam4_pkg::sinc_tap(p + SPS * m, CENTER, SPS, ONE));
    end
    logic signed [SUM_W-1:0] c;
    assign c = SUM_W'(bank[phase]);
    assign term[m] = !live[m] ? '0 : (pos[m] ? c : -c);
  end

  always_comb begin
    sum = '0;
    for (int m = 0; m < TAPS; m++) sum = sum + term[m];
  end
endmodule

// File: rtl/qam4_mix_out.sv
module qam4_mix_out #(
  parameter int SUM_W = 15,
  parameter int OUT_W = 8,
  parameter int SHIFT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic [1:0] quad,       // carrier quarter: sample index mod 4
  input  logic signed [SUM_W-1:0] i_sum,
  input  logic signed [SUM_W-1:0] q_sum,
  output logic [OUT_W-1:0] code
);
  localparam int MID  = 2 ** (OUT_W - 1);
  localparam int HI   = MID - 1;
  localparam int LO   = -MID;

  logic signed [SUM_W:0] mix;
  logic signed [SUM_W:0] scaled;
  int level;

  always_comb begin
    unique case (quad)
      2'd0: mix = (SUM_W+1)'(q_sum);
      2'd1: mix = (SUM_W+1)'(i_sum);
      2'd2: mix = -(SUM_W+1)'(q_sum);
      default: mix = -(SUM_W+1)'(i_sum);
    endcase
    scaled = mix >>> SHIFT;
    level  = int'(scaled);
    if (level > HI) level = HI;
    else if (level < LO) level = LO;
  end

  always_ff @(posedge clk) begin
    if (rst) code <= OUT_W'(MID);
    else if (en) code <= OUT_W'(level + MID);
  end
endmodule

// File: rtl/qam4_pulse_mod.sv
module qam4_pulse_mod #(
  parameter int SPS    = 16,
  parameter int TAPS   = 16,
  parameter int COEF_W = 10,
  parameter int OUT_W  = 8,
  parameter int SHIFT  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic sym_valid,
  input  logic [1:0] sym_bits,
  output logic sym_ready,
  output logic [OUT_W-1:0] dac_code
);
  localparam int PH_W  = $clog2(SPS);
  localparam int SUM_W = COEF_W + $clog2(TAPS) + 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(SPS - 1);

  logic [PH_W-1:0] phase;
  logic [TAPS-1:0] live, i_pos, q_pos;
  logic signed [SUM_W-1:0] i_sum, q_sum;
  logic take;

  assign sym_ready = sample_en && (phase == LAST);
  assign take      = sym_ready && sym_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      live  <= '0;
      i_pos <= '0;
      q_pos <= '0;
    end else if (sample_en) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
      if (phase == LAST) begin
        live  <= {live[TAPS-2:0], take};
        i_pos <= {i_pos[TAPS-2:0], take & sym_bits[1]};
        q_pos <= {q_pos[TAPS-2:0], take & sym_bits[0]};
      end
    end
  end

  qam4_shaper #(.SPS(SPS), .TAPS(TAPS), .COEF_W(COEF_W), .SUM_W(SUM_W)) u_shape_i (
    .phase(phase), .live(live), .pos(i_pos), .sum(i_sum));

  qam4_shaper #(.SPS(SPS), .TAPS(TAPS), .COEF_W(COEF_W), .SUM_W(SUM_W)) u_shape_q (
    .phase(phase), .live(live), .pos(q_pos), .sum(q_sum));

  qam4_mix_out #(.SUM_W(SUM_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_mix (
    .clk(clk), .rst(rst), .en(sample_en), .quad(phase[1:0]),
    .i_sum(i_sum), .q_sum(q_sum), .code(dac_code));
endmodule

// File: rtl/qam4_pulse_mod_chk.sv
module qam4_pulse_mod_chk #(
  parameter int OUT_W = 8,
  parameter int PH_W  = 4,
  parameter int SUM_W = 15
) (
  input logic clk,
  input logic rst,
  input logic sample_en,
  input logic sym_ready,
  input logic [OUT_W-1:0] dac_code,
  input logic [PH_W-1:0] phase,
  input logic signed [SUM_W-1:0] q_sum
);
  localparam logic [OUT_W-1:0] MID = OUT_W'(2 ** (OUT_W - 1));

  p_reset_mid_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dac_code == MID);

  p_ready_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    sym_ready |=> !sym_ready);

  p_phase_restart_r3: assert property (@(posedge clk) disable iff (rst)
    sym_ready |=> phase == '0);

  p_even_phase_zero_q_r6: assert property (@(posedge clk) disable iff (rst)
    (sample_en && !phase[0] && q_sum == '0) |=> dac_code == MID);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> $stable(dac_code));
endmodule

bind qam4_pulse_mod qam4_pulse_mod_chk #(.OUT_W(OUT_W), .PH_W(PH_W), .SUM_W(SUM_W)) u_chk (
  .clk(clk), .rst(rst), .sample_en(sample_en), .sym_ready(sym_ready),
  .dac_code(dac_code), .phase(phase), .q_sum(q_sum));

// File: tb/qam4_pulse_mod_bench.sv
`timescale 1ns/1ps
module qam4_pulse_mod_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_en = 1'b0;
  logic sym_valid = 1'b0;
  logic [1:0] sym_bits = 2'b00;
  logic sym_ready;
  logic [7:0] dac_code;

  always #2.5 clk = ~clk;

  qam4_pulse_mod u_qam4_pulse_mod (
    .clk(clk), .rst(rst), .sample_en(sample_en), .sym_valid(sym_valid),
    .sym_bits(sym_bits), .sym_ready(sym_ready), .dac_code(dac_code));

  int tests = 0;
  int fails = 0;
  int h [256];
  int ai [16];
  int aq [16];
  int mph = 0;
  int last_code = 128;
  int sat_hits = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int m = 0; m < 16; m++) begin ai[m] = 0; aq[m] = 0; end
    mph = 0;
    last_code = 128;
  endtask

  // One clock: drive, predict, check ready now and the output after the edge
  task automatic step(input bit en, input bit v, input logic [1:0] b, output bit took);
    int si, sq, mix, lvl;
    bit exp_rdy;
    sample_en = en; sym_valid = v; sym_bits = b;
    #1;
    exp_rdy = en && (mph == 15);
    chk(sym_ready == exp_rdy, "R2 ready", int'(sym_ready), int'(exp_rdy));
    took = exp_rdy && v;
    if (en) begin
      si = 0; sq = 0;
      for (int m = 0; m < 16; m++) begin
        si += ai[m] * h[mph + 16 * m];   // R4 shaping sum
        sq += aq[m] * h[mph + 16 * m];
      end
      case (mph % 4)                     // R6 quarter-rate carrier
        0: mix = sq;
        1: mix = si;
        2: mix = -sq;
        default: mix = -si;
      endcase
      lvl = mix >>> 2;                   // R8 floor scale and clamp
      if (lvl > 127) begin lvl = 127; sat_hits++; end
      else if (lvl < -128) begin lvl = -128; sat_hits++; end
      last_code = lvl + 128;
      if (mph == 15) begin
        for (int m = 15; m > 0; m--) begin ai[m] = ai[m-1]; aq[m] = aq[m-1]; end
        ai[0] = !took ? 0 : (b[1] ? 1 : -1);  // R5 mapping, R7 zero insert
        aq[0] = !took ? 0 : (b[0] ? 1 : -1);
      end
      mph = (mph + 1) % 16;                   // R3 period of 16
    end
    @(posedge clk);
    @(negedge clk);
    chk(int'(dac_code) == last_code, en ? "R4 R6 R8 sample" : "R9 hold", int'(dac_code), last_code);
  endtask

  function automatic logic [1:0] pat_bits(input int kind, input int k);
    case (kind)
      0: return 2'b11;
      1: return 2'b00;
      2: return (k % 2 == 1) ? 2'b01 : 2'b10;
      5: return 2'b11;
      default: return 2'((k * 5 + (k >> 2) + (k >> 3)) & 3);
    endcase
  endfunction

  // Run nsamp strobes of a stream; gap adds idle cycles with a changing offer (R9, R10)
  task automatic run_pattern(input int kind, input int nsamp, input bit gap);
    int k = 0;
    bit took;
    bit v;
    for (int s = 0; s < nsamp; s++) begin
      if (kind == 5) v = (k == 0);
      else if (kind == 4) v = ((s / 16) % 3 != 1);
      else v = 1'b1;
      if (gap) step(1'b0, 1'b1, pat_bits(kind, k + 7), took);  // R10: not consumed
      step(1'b1, v, pat_bits(kind, k), took);
      if (took) k++;
    end
  endtask

  initial begin
    real t, x;
    bit dummy;
    for (int n = 0; n < 256; n++) begin
      if ((n - 128) % 16 == 0) h[n] = (n == 128) ? 256 : 0;
      else begin
        t = real'(n - 128) / 16.0;
        x = 3.14159265358979 * t;
        h[n] = $rtoi($floor(256.0 * $sin(x) / x + 0.5));
      end
    end
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(dac_code == 8'd128, "R1 reset code", int'(dac_code), 128);
    chk(sym_ready == 1'b0, "R1 ready idle", int'(sym_ready), 0);

    run_pattern(0, 320, 1'b0);
    run_pattern(1, 320, 1'b0);
    run_pattern(2, 400, 1'b0);
    run_pattern(3, 320, 1'b1);
    run_pattern(4, 400, 1'b0);

    // mid-stream reset
    sample_en = 1'b1; sym_valid = 1'b1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0; sample_en = 1'b0;
    model_reset();
    chk(dac_code == 8'd128, "R1 mid reset code", int'(dac_code), 128);
    for (int i = 0; i < 15; i++) step(1'b1, 1'b1, 2'b11, dummy);
    step(1'b1, 1'b0, 2'b00, dummy);   // R1: 16th strobe after reset shows ready (checked inside)

    model_reset();
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    run_pattern(5, 300, 1'b0);        // single pulse, then silence
    chk(dac_code == 8'd128, "R7 silence mid-scale", int'(dac_code), 128);
    chk(sat_hits > 0, "R8 saturation reached", sat_hits, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule